// File: doc/BRIEF.md
# Raster Line Interrupt Generator

This block turns raster timing strobes into an interrupt priority level for a main processor. A programmable down-counter tracks visible lines and raises a line interrupt every `reload + 1` visible lines. A vertical-blank interrupt is raised when the raster reaches the first blanking line. An external sound-chip interrupt line is merged in at the lowest priority.

The raster timing source supplies a one-cycle line-start strobe, a one-cycle line-end strobe and the current line number, which is valid while the strobes are high. The two strobes never fall in the same cycle. Software-owned settings arrive as a line-interrupt enable and an 8-bit reload value. Line and vertical-blank requests clear themselves, so no acknowledge path is needed. The output is a 3-bit encoded level.

Top module: `raster_irq_gen`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `irq_level` is 0 whenever `snd_irq` is low. Reset loads the line counter from `reload_val`, so the first line interrupt of the frame follows the line-end of visible line `reload_val`.
- R2: On the line-end of a visible line (0 to 223), a counter at zero is reloaded and a line request is raised. Otherwise the counter decrements. With the counter loaded at frame start, requests follow the line-end of each visible line L where (L+1) mod (reload_val+1) = 0. Reload 0 gives a request after every visible line.
- R3: When `line_irq_en` is low at an expiring line-end, no line request is raised, but the counter still reloads.
- R4: A line request is visible from the cycle after its line-end and is cleared by the next line-start strobe. It is gone one cycle after that strobe.
- R5: On the line-end of every blanking line (224 to 261), the counter is reloaded. The count pattern therefore restarts each frame and does not depend on what was left over from the previous frame.
- R6: A line-start strobe with line number 224 raises the vertical-blank request in the next cycle, once per frame. The request stays for exactly `VBL_PULSE_CYCLES` cycles (default 16) and then clears by itself.
- R7: `irq_level` encodes the highest active request: 6 for vertical blank, 4 for line, 2 for sound, 0 for none. Bit 0 is always 0.
- R8: `snd_irq` is level-sensitive and reaches `irq_level` in the same cycle, with no register in between. A low `snd_irq` with no other request gives level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | One-cycle strobe at the start of a raster line |
| line_end | input | 1 | One-cycle strobe at the end of a raster line |
| line_num | input | 9 | Current line number (0 to 261), valid with the strobes |
| line_irq_en | input | 1 | Line interrupt enable |
| reload_val | input | 8 | Line counter reload value |
| snd_irq | input | 1 | Level interrupt from the sound chip |
| irq_level | output | 3 | Encoded priority level: 6, 4, 2 or 0 |

## Verification
The line counter is driven over whole frames with several reload values:
- Reload 0 tells an every-line period apart from an off-by-one period.
- Reload 3 and a few random small values show the period.
- Reload 100 leaves 22 counts unused at the end of the visible area, so it shows whether the blanking reload restarts the pattern each frame.
- Reload 223 and 255 test the one-hit and no-hit edges of the visible area.

A frame with the enable low separates gating from counting. Random sound activity on every line checks that priority ordering holds against line and vertical-blank requests. The window around line 224 checks when the vertical-blank pulse begins and ends.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;

    typedef enum logic [2:0] {
        LVL_NONE   = 3'd0,
        LVL_SOUND  = 3'd2,
        LVL_LINE   = 3'd4,
        LVL_VBLANK = 3'd6
    } irq_level_e;

endpackage

// File: rtl/raster_line_counter.sv
module raster_line_counter #(
    parameter int RELOAD_W      = 8,
    parameter int LINE_W        = 9,
    parameter int VISIBLE_LINES = 224
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_start,
    input  logic                line_end,
    input  logic [LINE_W-1:0]   line_num,
    input  logic                irq_en,
    input  logic [RELOAD_W-1:0] reload,
    output logic                line_req
);
    localparam logic [LINE_W-1:0] FIRST_BLANK = LINE_W'(VISIBLE_LINES);

    typedef struct packed {
        logic [RELOAD_W-1:0] cnt;
        logic                req;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       in_visible;

    assign in_visible = (line_num < FIRST_BLANK);

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.cnt = reload;
            st_d.req = 1'b0;
        end else begin
            if (line_start) begin
                st_d.req = 1'b0;
            end
            if (line_end) begin
                if (!in_visible) begin
                    st_d.cnt = reload;
                end else if (st_q.cnt == '0) begin
                    st_d.cnt = reload;
                    st_d.req = irq_en;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign line_req = st_q.req;

endmodule

// File: rtl/raster_vblank_pulse.sv
module raster_vblank_pulse #(
    parameter int LINE_W           = 9,
    parameter int VISIBLE_LINES    = 224,
    parameter int VBL_PULSE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    output logic              vbl_req
);
    localparam int PULSE_W = $clog2(VBL_PULSE_CYCLES + 1);
    localparam logic [LINE_W-1:0]  FIRST_BLANK = LINE_W'(VISIBLE_LINES);
    localparam logic [PULSE_W-1:0] LAST_TICK   = PULSE_W'(VBL_PULSE_CYCLES - 1);

    typedef struct packed {
        logic [PULSE_W-1:0] tmr;
        logic               req;
    } vbl_state_t;

    vbl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.tmr = '0;
            st_d.req = 1'b0;
        end else if (line_start && line_num == FIRST_BLANK) begin
            st_d.tmr = LAST_TICK;
            st_d.req = 1'b1;
        end else if (st_q.req) begin
            if (st_q.tmr == '0) begin
                st_d.req = 1'b0;
            end else begin
                st_d.tmr = st_q.tmr - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign vbl_req = st_q.req;

endmodule

// File: rtl/raster_level_encoder.sv
module raster_level_encoder
    import raster_irq_pkg::*;
(
    input  logic       vbl_req,
    input  logic       line_req,
    input  logic       snd_req,
    output logic [2:0] level
);
    irq_level_e lvl;

    always_comb begin
        if (vbl_req)       lvl = LVL_VBLANK;
        else if (line_req) lvl = LVL_LINE;
        else if (snd_req)  lvl = LVL_SOUND;
        else               lvl = LVL_NONE;
    end

    assign level = lvl;

endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen #(
    parameter int RELOAD_W         = 8,
    parameter int TOTAL_LINES      = 262,
    parameter int VISIBLE_LINES    = 224,
    parameter int VBL_PULSE_CYCLES = 16,
    localparam int LINE_W          = $clog2(TOTAL_LINES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_start,
    input  logic                line_end,
    input  logic [LINE_W-1:0]   line_num,
    input  logic                line_irq_en,
    input  logic [RELOAD_W-1:0] reload_val,
    input  logic                snd_irq,
    output logic [2:0]          irq_level
);
    logic line_req;
    logic vbl_req;

    raster_line_counter #(
        .RELOAD_W(RELOAD_W), .LINE_W(LINE_W), .VISIBLE_LINES(VISIBLE_LINES)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_end(line_end),
        .line_num(line_num), .irq_en(line_irq_en), .reload(reload_val),
        .line_req(line_req)
    );

    raster_vblank_pulse #(
        .LINE_W(LINE_W), .VISIBLE_LINES(VISIBLE_LINES),
        .VBL_PULSE_CYCLES(VBL_PULSE_CYCLES)
    ) u_vbl (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .line_num(line_num), .vbl_req(vbl_req)
    );

    raster_level_encoder u_enc (
        .vbl_req(vbl_req), .line_req(line_req), .snd_req(snd_irq),
        .level(irq_level)
    );

endmodule

// File: rtl/raster_irq_chk.sv
module raster_irq_chk #(
    parameter int LINE_W        = 9,
    parameter int VISIBLE_LINES = 224
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_start,
    input logic              line_end,
    input logic [LINE_W-1:0] line_num,
    input logic              snd_irq,
    input logic [2:0]        irq_level
);
    localparam logic [LINE_W-1:0] FIRST_BLANK = LINE_W'(VISIBLE_LINES);

    // R7
    level_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level[0] == 1'b0 && irq_level != 3'd0 || irq_level == 3'd0);

    // R6
    vbl_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && line_num == FIRST_BLANK) |=> irq_level == 3'd6);

    // R4
    line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !line_end && line_num != FIRST_BLANK) |=> irq_level != 3'd4);

    // R8
    snd_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snd_irq |-> irq_level != 3'd0);

endmodule

bind raster_irq_gen raster_irq_chk #(
    .LINE_W(LINE_W), .VISIBLE_LINES(VISIBLE_LINES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_end(line_end),
    .line_num(line_num), .snd_irq(snd_irq), .irq_level(irq_level)
);

// File: tb/sim_raster_irq_gen.sv
module sim_raster_irq_gen;
    localparam int TOTAL   = 262;
    localparam int VISIBLE = 224;
    localparam int FRAMES  = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_start = 1'b0;
    logic       line_end = 1'b0;
    logic [8:0] line_num = '0;
    logic       line_irq_en = 1'b0;
    logic [7:0] reload_val = '0;
    logic       snd_irq = 1'b0;
    logic [2:0] irq_level;

    int checks = 0;
    int errors = 0;
    int cfg_r  [FRAMES];
    bit cfg_en [FRAMES];

    always #2.5 clk = ~clk;

    raster_irq_gen u0 (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_end(line_end),
        .line_num(line_num), .line_irq_en(line_irq_en), .reload_val(reload_val),
        .snd_irq(snd_irq), .irq_level(irq_level)
    );

    function automatic logic [2:0] exp_level(bit vbl, bit line_hit, bit snd);
        if (vbl)           return 3'd6;
        else if (line_hit) return 3'd4;
        else if (snd)      return 3'd2;
        return 3'd0;
    endfunction

    function automatic bit line_hits(int l, int r, bit en);
        return en && (l < VISIBLE) && (((l + 1) % (r + 1)) == 0);
    endfunction

    task automatic check(string tag, logic [2:0] got, logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: irq_level=%0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic run_line(int f, int l);
        int r = cfg_r[f];
        bit en = cfg_en[f];
        @(negedge clk);
        snd_irq = ($urandom % 4) == 0;
        line_num = 9'(l);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        if (l == VISIBLE) check("R6 vblank raise", irq_level, 3'd6);
        else if (l == VISIBLE + 1) check("R6 vblank held", irq_level, 3'd6);
        else if (l == VISIBLE + 3) check("R6 vblank cleared", irq_level, exp_level(0, 0, snd_irq));
        else if (l < VISIBLE) check("R4 line req cleared", irq_level, exp_level(0, 0, snd_irq));
        @(negedge clk);
        if (l == VISIBLE + 6) begin
            snd_irq = 1'b1;
            #1 check("R8 sound follows high", irq_level, 3'd2);
            snd_irq = 1'b0;
            #1 check("R8 sound follows low", irq_level, 3'd0);
        end
        @(negedge clk);
        line_end = 1'b1;
        @(negedge clk);
        line_end = 1'b0;
        if (l < VISIBLE) begin
            if (f == 2) check("R5 R2 blank reload pattern", irq_level, exp_level(0, line_hits(l, r, en), snd_irq));
            else if (!en) check("R3 enable gate", irq_level, exp_level(0, 0, snd_irq));
            else check("R2 R7 line period", irq_level, exp_level(0, line_hits(l, r, en), snd_irq));
        end
        if (l == 240 && f + 1 < FRAMES) begin
            reload_val = 8'(cfg_r[f + 1]);
            line_irq_en = cfg_en[f + 1];
        end
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd4242));
        cfg_r[0] = 3;   cfg_en[0] = 1;
        cfg_r[1] = 0;   cfg_en[1] = 1;
        cfg_r[2] = 100; cfg_en[2] = 1;
        cfg_r[3] = 223; cfg_en[3] = 1;
        cfg_r[4] = 255; cfg_en[4] = 1;
        cfg_r[5] = 5;   cfg_en[5] = 0;
        for (int i = 6; i < FRAMES; i++) begin
            cfg_r[i]  = $urandom % 41;
            cfg_en[i] = ($urandom % 4) != 0;
        end
        reload_val  = 8'(cfg_r[0]);
        line_irq_en = cfg_en[0];
        repeat (4) @(negedge clk);
        check("R1 level during reset", irq_level, 3'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 level after reset", irq_level, 3'd0);
        for (int f = 0; f < FRAMES; f++) begin
            for (int l = 0; l < TOTAL; l++) begin
                run_line(f, l);
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule